// File: doc/BRIEF.md
# Register-Driven Serial Flash Command Engine

This block issues one serial flash command at a time from a small set of byte-wide registers. Software loads a command byte, a packed pair of byte counts and up to eight outgoing data bytes, then sets a start bit. The engine lowers chip select and sends the command byte from its own register. It then sends the data bytes held in an 8-entry byte store, and clocks in the requested number of reply bytes.

Outgoing and incoming bytes share the byte store and a single access pointer. Reply bytes are written into the store directly after the outgoing bytes, so software resets the pointer and reads past its own data before it reaches the reply. When no data bytes are sent, the reply count field is one larger than the number of reply bytes wanted, and the engine removes that extra one. The serial side runs in SPI mode 0 with the serial clock derived from the system clock by a fixed divider.

Top module: `spi_cmd_engine`

## Requirements
- R1: After synchronous reset the registers at offsets 0x0, 0x1, 0x2, 0x3 and 0xD read 0, spi_cs_n is 1, and spi_sck and spi_mosi are 0.
- R2: Offset 0x0 holds the command byte and offset 0x1 the count byte (bits [3:0] outgoing data bytes, bits [7:4] reply field); both read back as written.
- R3: Each write or read at offset 0xC accesses the store entry named by the pointer and moves the pointer up by one, wrapping from 7 to 0; offset 0xD returns the pointer in bits [2:0] with bits [7:3] at 0.
- R4: Writing offset 0x2 with bit 4 set returns the pointer to 0; bit 4 reads back as 0.
- R5: Writing offset 0x2 with bit 0 set starts a command; bit 0 of offset 0x2 and bit 7 of offset 0x3 read 1 while it runs and 0 once it ends.
- R6: A command sends, MSB first, the command byte, then store entries 0 upward for the outgoing count, then a 0 on spi_mosi during each reply byte. Each bit lasts SCK_DIV clocks: spi_sck is low for the first half and high for the second, and spi_mosi changes only when spi_sck falls.
- R7: spi_miso is sampled as spi_sck rises; reply byte k is written to store entry (outgoing count + k) mod 8.
- R8: With an outgoing count of 0, the number of reply bytes is the reply field minus one (a field of 0 gives no reply byte); otherwise it is the reply field.
- R9: An outgoing count field above 8 is treated as 8.
- R10: spi_cs_n falls on the clock edge that accepts the start write, the first spi_sck rise follows SCK_DIV/2 clocks later, and spi_cs_n rises with busy clearing SCK_DIV clocks after the last spi_sck fall.
- R11: While a command runs, writes to offsets 0x0, 0x1 and 0x2 have no effect.
- R12: Read data appears on bus_rdata on the clock after the read request; offsets outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, registered |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A read result is due one clock after its strobe, and the bench samples it on the following falling clock edge. The serial pins are predicted for every clock from the edge that accepted the start write. The predicted frame has spi_sck rising SCK_DIV/2 clocks into each bit and falling at its end, with spi_cs_n rising SCK_DIV clocks after the last fall. These three pins are compared with the prediction on each falling clock edge. Busy is predicted from the same count, so reads and ignored writes near the end of a command are judged against the exact edge at which the engine returns to idle.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // Byte offsets of the register window; software depends on these.
  localparam logic [3:0] OFS_OPCODE = 4'h0;
  localparam logic [3:0] OFS_COUNT  = 4'h1;
  localparam logic [3:0] OFS_CTRL   = 4'h2;
  localparam logic [3:0] OFS_STAT   = 4'h3;
  localparam logic [3:0] OFS_DATA   = 4'hC;
  localparam logic [3:0] OFS_PTR    = 4'hD;

  // Bit positions inside the control and status bytes.
  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 4;
  localparam int STAT_BUSY_BIT = 7;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SHIFT,
    ENG_TAIL
  } eng_state_t;

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  input  logic             bus_rd,
  output logic [7:0]       bus_rdata,
  input  logic             busy,
  input  logic [PTR_W-1:0] fifo_ptr,
  input  logic [7:0]       fifo_rdata,
  output logic [7:0]       opcode,
  output logic [3:0]       tx_field,
  output logic [3:0]       rx_field,
  output logic             go,
  output logic             ptr_clr,
  output logic             fifo_wr,
  output logic             fifo_rd
);

  logic [7:0] opcode_q;
  logic [7:0] count_q;
  logic [7:0] rdata_q;
  logic       data_sel_q;
  logic       cfg_wr_ok;

  assign cfg_wr_ok = bus_wr && !busy;
  assign go        = cfg_wr_ok && (bus_addr == OFS_CTRL) && bus_wdata[CTRL_GO_BIT];
  assign ptr_clr   = cfg_wr_ok && (bus_addr == OFS_CTRL) && bus_wdata[CTRL_CLR_BIT];
  assign fifo_wr   = bus_wr && (bus_addr == OFS_DATA);
  assign fifo_rd   = bus_rd && (bus_addr == OFS_DATA);

  assign opcode   = opcode_q;
  assign tx_field = count_q[3:0];
  assign rx_field = count_q[7:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode_q <= '0;
      count_q  <= '0;
    end else if (cfg_wr_ok) begin
      if (bus_addr == OFS_OPCODE) opcode_q <= bus_wdata;
      if (bus_addr == OFS_COUNT)  count_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      data_sel_q <= 1'b0;
    end else if (bus_rd) begin
      data_sel_q <= (bus_addr == OFS_DATA);
      unique case (bus_addr)
        OFS_OPCODE: rdata_q <= opcode_q;
        OFS_COUNT:  rdata_q <= count_q;
        OFS_CTRL:   rdata_q <= {7'b0, busy};
        OFS_STAT:   rdata_q <= {busy, 7'b0};
        OFS_PTR:    rdata_q <= 8'(fifo_ptr);
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = data_sel_q ? fifo_rdata : rdata_q;

  AST_OPCODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr == OFS_OPCODE) |=> $stable(opcode_q)); // R11
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr == OFS_COUNT) |=> $stable(count_q)); // R11

endmodule

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic [PTR_W-1:0] ptr,
  input  logic [PTR_W-1:0] eng_raddr,
  output logic [7:0]       eng_rdata,
  input  logic             eng_we,
  input  logic [PTR_W-1:0] eng_waddr,
  input  logic [7:0]       eng_wdata
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       host_rdata_q;
  logic [7:0]       eng_rdata_q;

  // Storage: one write port shared by engine (priority) and host, registered reads.
  always_ff @(posedge clk) begin
    if (eng_we) begin
      mem[eng_waddr] <= eng_wdata;
    end else if (host_wr) begin
      mem[ptr_q] <= host_wdata;
    end
    if (host_rd) host_rdata_q <= mem[ptr_q];
    eng_rdata_q <= mem[eng_raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (clr) begin
      ptr_q <= '0;
    end else if (host_wr || host_rd) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr        = ptr_q;
  assign host_rdata = host_rdata_q;
  assign eng_rdata  = eng_rdata_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    ((host_wr || host_rd) && !clr) |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1)); // R3
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> ptr_q == '0); // R4

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int SCK_DIV = 4,
  parameter int DEPTH   = 8,
  parameter int PTR_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [7:0]       opcode,
  input  logic [3:0]       tx_field,
  input  logic [3:0]       rx_field,
  output logic             busy,
  output logic [PTR_W-1:0] eng_raddr,
  input  logic [7:0]       eng_rdata,
  output logic             eng_we,
  output logic [PTR_W-1:0] eng_waddr,
  output logic [7:0]       eng_wdata,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);

  localparam int HALF = SCK_DIV / 2;
  localparam int DW   = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
  localparam int NB_W = $clog2(DEPTH + 17);

  eng_state_t       state_q;
  logic [DW-1:0]    div_q;
  logic [2:0]       bit_q;
  logic [NB_W-1:0]  byte_q;
  logic [NB_W-1:0]  last_q;
  logic [NB_W-1:0]  txn_q;
  logic [PTR_W-1:0] didx_q;
  logic [PTR_W-1:0] widx_q;
  logic [7:0]       sh_q;
  logic [7:0]       rx_q;
  logic             sck_q;
  logic             cs_n_q;

  logic [NB_W-1:0]  tx_eff;
  logic [NB_W-1:0]  rx_eff;
  logic [NB_W-1:0]  nb_total;
  logic             div_mid;
  logic             div_end;
  logic             byte_end;

  // Count decoding: clamp outgoing count, drop the extra reply unit when nothing is sent.
  always_comb begin
    tx_eff = (tx_field > DEPTH) ? NB_W'(DEPTH) : NB_W'(tx_field);
    if (tx_field == 4'd0) begin
      rx_eff = (rx_field == 4'd0) ? '0 : NB_W'(rx_field - 4'd1);
    end else begin
      rx_eff = NB_W'(rx_field);
    end
    nb_total = NB_W'(1) + tx_eff + rx_eff;
  end

  assign div_mid  = (div_q == DW'(HALF - 1));
  assign div_end  = (div_q == DW'(SCK_DIV - 1));
  assign byte_end = (state_q == ENG_SHIFT) && div_end && (bit_q == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      last_q  <= '0;
      txn_q   <= '0;
      didx_q  <= '0;
      widx_q  <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          if (go) begin
            state_q <= ENG_SHIFT;
            cs_n_q  <= 1'b0;
            div_q   <= '0;
            bit_q   <= '0;
            byte_q  <= '0;
            last_q  <= nb_total - 1'b1;
            txn_q   <= tx_eff;
            didx_q  <= '0;
            widx_q  <= tx_eff[PTR_W-1:0];
            sh_q    <= opcode;
          end
        end
        ENG_SHIFT: begin
          div_q <= div_end ? '0 : div_q + 1'b1;
          if (div_mid) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso};
          end
          if (div_end) begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              bit_q <= '0;
              if (byte_q > txn_q) widx_q <= widx_q + 1'b1;
              if (byte_q == last_q) begin
                state_q <= ENG_TAIL;
                sh_q    <= '0;
              end else begin
                byte_q <= byte_q + 1'b1;
                if (byte_q < txn_q) begin
                  sh_q   <= eng_rdata;
                  didx_q <= didx_q + 1'b1;
                end else begin
                  sh_q <= '0;
                end
              end
            end else begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end
        ENG_TAIL: begin
          div_q <= div_end ? '0 : div_q + 1'b1;
          if (div_end) begin
            cs_n_q  <= 1'b1;
            state_q <= ENG_IDLE;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ENG_IDLE);
  assign eng_raddr = didx_q;
  assign eng_we    = byte_end && (byte_q > txn_q);
  assign eng_waddr = widx_q;
  assign eng_wdata = rx_q;
  assign sck       = sck_q;
  assign cs_n      = cs_n_q;
  assign mosi      = sh_q[7];

  AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    sck_q |-> !cs_n_q); // R6
  AST_MOSI_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_q) |-> $stable(sh_q[7])); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ENG_IDLE) |-> (cs_n_q && !sck_q && !sh_q[7])); // R10
  AST_GO_SELECTS: assert property (@(posedge clk) disable iff (rst)
    (go && state_q == ENG_IDLE) |=> (!cs_n_q && busy)); // R5
  AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    busy |-> (byte_q <= last_q && txn_q <= NB_W'(DEPTH))); // R9

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int SCK_DIV    = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int PTR_W = $clog2(FIFO_DEPTH);

  logic             busy;
  logic [PTR_W-1:0] fifo_ptr;
  logic [7:0]       fifo_host_rdata;
  logic [7:0]       opcode;
  logic [3:0]       tx_field;
  logic [3:0]       rx_field;
  logic             go;
  logic             ptr_clr;
  logic             fifo_wr;
  logic             fifo_rd;
  logic [PTR_W-1:0] eng_raddr;
  logic [7:0]       eng_rdata;
  logic             eng_we;
  logic [PTR_W-1:0] eng_waddr;
  logic [7:0]       eng_wdata;

  spi_cmd_regs #(.PTR_W(PTR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .fifo_ptr   (fifo_ptr),
    .fifo_rdata (fifo_host_rdata),
    .opcode     (opcode),
    .tx_field   (tx_field),
    .rx_field   (rx_field),
    .go         (go),
    .ptr_clr    (ptr_clr),
    .fifo_wr    (fifo_wr),
    .fifo_rd    (fifo_rd)
  );

  spi_cmd_fifo #(.DEPTH(FIFO_DEPTH), .PTR_W(PTR_W)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .clr        (ptr_clr),
    .host_wr    (fifo_wr),
    .host_rd    (fifo_rd),
    .host_wdata (bus_wdata),
    .host_rdata (fifo_host_rdata),
    .ptr        (fifo_ptr),
    .eng_raddr  (eng_raddr),
    .eng_rdata  (eng_rdata),
    .eng_we     (eng_we),
    .eng_waddr  (eng_waddr),
    .eng_wdata  (eng_wdata)
  );

  spi_cmd_shifter #(.SCK_DIV(SCK_DIV), .DEPTH(FIFO_DEPTH), .PTR_W(PTR_W)) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .opcode    (opcode),
    .tx_field  (tx_field),
    .rx_field  (rx_field),
    .busy      (busy),
    .eng_raddr (eng_raddr),
    .eng_rdata (eng_rdata),
    .eng_we    (eng_we),
    .eng_waddr (eng_waddr),
    .eng_wdata (eng_wdata),
    .sck       (spi_sck),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .miso      (spi_miso)
  );

endmodule

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int HALF       = DIV / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t0 = 0;
  int nb = 0;
  bit run = 1'b0;
  bit live = 1'b0;
  int sl_cnt = 0;

  logic [7:0] fr [0:31];
  logic [7:0] m_fifo [0:7];
  logic [7:0] m_op = '0;
  logic [7:0] m_cnt = '0;
  int         m_ptr = 0;
  logic [7:0] seed = 8'h5A;

  spi_cmd_engine #(.SCK_DIV(DIV), .FIFO_DEPTH(8)) i_spi_cmd_engine (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Flash-side responder: byte j of a frame is a pattern of j and seed.
  function automatic logic [7:0] resp_byte(int j);
    return 8'(j * 59) ^ seed;
  endfunction

  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) sl_cnt <= 0;
    else          sl_cnt <= sl_cnt + 1;
  end

  always_comb begin
    logic [7:0] rb;
    rb = resp_byte(sl_cnt / 8);
    spi_miso = rb[7 - (sl_cnt % 8)];
  end

  function automatic int frame_end();
    return (nb * 8 + 1) * DIV;
  endfunction

  // Busy as seen just before the most recent rising edge.
  function automatic bit busy_edge();
    return run && ((cyc - 1 - t0) < frame_end());
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start_model();
    int tx, rx, txc, rxc;
    tx  = int'(m_cnt[3:0]);
    rx  = int'(m_cnt[7:4]);
    txc = (tx > 8) ? 8 : tx;
    rxc = (tx == 0) ? ((rx == 0) ? 0 : rx - 1) : rx;
    nb  = 1 + txc + rxc;
    fr[0] = m_op;
    for (int i = 0; i < txc; i++) fr[1 + i] = m_fifo[i];
    for (int k = 0; k < rxc; k++) begin
      fr[1 + txc + k] = 8'h00;
      m_fifo[(txc + k) % 8] = resp_byte(1 + txc + k);
    end
    t0  = cyc;
    run = 1'b1;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bit bz;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    bz = busy_edge();
    case (a)
      4'h0: if (!bz) m_op = d;
      4'h1: if (!bz) m_cnt = d;
      4'h2: if (!bz) begin
              if (d[4]) m_ptr = 0;
              if (d[0]) start_model();
            end
      4'hC: begin m_fifo[m_ptr] = d; m_ptr = (m_ptr + 1) % 8; end
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [3:0] a, input string req);
    bit bz;
    int e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    bz = busy_edge();
    case (a)
      4'h0: e = int'(m_op);
      4'h1: e = int'(m_cnt);
      4'h2: e = int'(bz);
      4'h3: e = bz ? 8'h80 : 0;
      4'hC: begin e = int'(m_fifo[m_ptr]); m_ptr = (m_ptr + 1) % 8; end
      4'hD: e = m_ptr;
      default: e = 0;
    endcase
    @(negedge clk);
    check(req, int'(bus_rdata), e);
  endtask

  task automatic wait_idle();
    while (run && (cyc - t0) < frame_end()) @(negedge clk);
    @(negedge clk);
  endtask

  // Per-clock comparison of the serial pins against the predicted frame.
  always @(negedge clk) begin
    if (live) begin
      int k;
      logic [2:0] e;
      k = cyc - t0;
      if (run && k < frame_end()) begin
        if (k < nb * 8 * DIV) begin
          int b, ph;
          b  = k / DIV;
          ph = k % DIV;
          e  = {1'b0, ph >= HALF, fr[b / 8][7 - (b % 8)]};
        end else begin
          e = 3'b000;
        end
      end else begin
        e = 3'b100;
      end
      check("R6 R10 frame pins", int'({spi_cs_n, spi_sck, spi_mosi}), int'(e));
    end
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;

    // R1: reset values
    bus_read(4'h0, "R1 opcode after reset");
    bus_read(4'h1, "R1 count after reset");
    bus_read(4'h2, "R1 control after reset");
    bus_read(4'h3, "R1 status after reset");
    bus_read(4'hD, "R1 pointer after reset");

    // R2, R12: readback and unmapped offset
    bus_write(4'h0, 8'h9F);
    bus_write(4'h1, 8'h30);
    bus_read(4'h0, "R2 opcode readback");
    bus_read(4'h1, "R2 count readback");
    bus_read(4'h5, "R12 unmapped offset");

    // R3, R4: pointer stepping, wrap and clear
    bus_write(4'h2, 8'h10);
    for (int i = 0; i < 9; i++) bus_write(4'hC, 8'(8'h10 + i));
    bus_read(4'hD, "R3 pointer wrapped");
    bus_write(4'h2, 8'h10);
    bus_read(4'hD, "R4 pointer cleared");
    bus_read(4'h2, "R4 clear bit reads 0");
    for (int i = 0; i < 3; i++) bus_read(4'hC, "R3 store readback");
    bus_read(4'hD, "R3 pointer after reads");

    // Command A: 3 data bytes out, 4 reply bytes
    bus_write(4'h0, 8'h03);
    bus_write(4'h1, 8'h43);
    bus_write(4'h2, 8'h10);
    bus_write(4'hC, 8'h12);
    bus_write(4'hC, 8'h34);
    bus_write(4'hC, 8'h56);
    seed = 8'h5A;
    bus_write(4'h2, 8'h01);
    bus_read(4'h3, "R5 status busy");
    bus_read(4'h2, "R5 control go held");
    bus_write(4'h0, 8'hFF);   // R11 ignored
    bus_write(4'h1, 8'h00);   // R11 ignored
    bus_write(4'h2, 8'h10);   // R11 ignored
    bus_write(4'h2, 8'h01);   // R11 no restart
    wait_idle();
    bus_read(4'h3, "R5 status idle");
    bus_read(4'h2, "R5 control go cleared");
    bus_read(4'h0, "R11 opcode kept");
    bus_read(4'h1, "R11 count kept");
    bus_read(4'hD, "R11 pointer kept");
    bus_write(4'h2, 8'h10);
    for (int i = 0; i < 7; i++) bus_read(4'hC, "R7 echo then reply");

    // Command B: no data out, reply field 3 gives 2 bytes
    seed = 8'hC3;
    bus_write(4'h1, 8'h30);
    bus_write(4'h0, 8'h9F);
    bus_write(4'h2, 8'h01);
    wait_idle();
    bus_write(4'h2, 8'h10);
    for (int i = 0; i < 3; i++) bus_read(4'hC, "R8 reply minus one");

    // Command C: opcode only, reply field 0
    bus_write(4'h1, 8'h00);
    bus_write(4'h0, 8'h06);
    bus_write(4'h2, 8'h01);
    wait_idle();
    bus_read(4'h2, "R8 empty reply done");
    bus_write(4'h2, 8'h10);
    bus_read(4'hC, "R8 store untouched");

    // Command D: data field 12 clamps to 8, one reply byte wraps to entry 0
    seed = 8'h71;
    bus_write(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) bus_write(4'hC, 8'(8'hA0 + i));
    bus_write(4'h1, 8'h1C);
    bus_write(4'h0, 8'h02);
    bus_write(4'h2, 8'h11);
    bus_read(4'hD, "R9 pointer cleared at start");
    wait_idle();
    bus_write(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) bus_read(4'hC, "R9 clamp and wrap");

    repeat (4) @(negedge clk);
    report();
    $finish;
  end

endmodule